// File: doc/BRIEF.md
# Dual Mode-Programmable Timer/Counter

Two independent up-counting channels share one 8-bit mode register. Each channel has a four-bit control field: a gate enable, a timer/counter select and a two-bit overflow mode. Each channel also has a run bit, a low and a high count byte and an overflow flag. In timer mode a channel advances once per machine cycle. A machine cycle is twelve input clocks, produced by an internal divider. In counter mode a channel counts falling edges on its own event pin, which is sampled once per machine cycle. When the gate bit is set, counting also requires the channel's gate pin to be high.

There are four overflow modes: a 13-bit count with a 5-bit prescaler, a 16-bit count, an 8-bit count that reloads from the high byte, and a split mode. In split mode channel 0's two bytes become two separate 8-bit counters and channel 1 is halted. The mode register and the run bits are staged. A write to them takes effect at the next end-of-instruction strobe. The count bytes can be read and written at any time while a channel runs, and each overflow raises a flag that software or an acknowledge input clears.

Top module: `twin_timer`

## Requirements
- R1: After reset every register reads zero and both overflow flags are low. Register addresses: 0 mode, 1 control, 2 channel 0 low byte, 3 channel 0 high byte, 4 channel 1 low byte, 5 channel 1 high byte.
- R2: Writes to the mode register (address 0) and to the run bits (control bit 0 for channel 0, bit 1 for channel 1) only stage a value. The staged value becomes active, and readable, in the clock cycle after `cycleEnd` is high. `cycleEnd` may arrive in the same cycle as the write.
- R3: In timer mode (select bit clear), a running channel increments exactly once per 12 clocks. A channel whose run bit is 0 holds its count.
- R4: When the gate bit is set (mode bit 3 for channel 0, bit 7 for channel 1), the channel counts only while its `gatePin` is high.
- R5: Mode 0 (mode field 00; bits 1:0 for channel 0, bits 5:4 for channel 1) counts the 13-bit value {high byte, low byte bits 4:0}. Low byte bits 7:5 stay unchanged. Rolling over from all ones to zero sets the flag.
- R6: Mode 1 (field 01) counts {high, low} as a 16-bit value. Rolling over from FFFF to 0000 sets the flag.
- R7: Mode 2 (field 10) counts the low byte only. When it is incremented at FF it loads the high byte instead and sets the flag. The high byte is unchanged.
- R8: Mode 3 (field 11) on channel 0 counts the low byte as an 8-bit counter under channel 0's controls and flag. The high byte counts machine cycles whenever run bit 1 is set, and its rollover sets flag 1. Channel 1's bytes are frozen while channel 0 is in mode 3.
- R9: In counter mode (select bit 2 for channel 0, bit 6 for channel 1), the channel counts one per high-to-low change of its `eventPin` between two successive once-per-machine-cycle samples. A pin held high and low for 24 clocks each is counted exactly once per pulse.
- R10: An event increment appears exactly one machine cycle (12 clocks) after the sample that found the pin low.
- R11: A flag is cleared by `ackFlag` or by writing 0 to its control bit (bit 4 for flag 0, bit 5 for flag 1). Writing 1 has no effect. The flags read back on those bits and appear on `ovfFlag`.
- R12: A count byte written while its channel runs reads back the written value on the next cycle, even if an increment fell in the write cycle. Counting then continues from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one oscillator period |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 8 | Read data (combinational) |
| cycleEnd | input | 1 | End-of-instruction strobe committing staged mode and run bits |
| eventPin | input | 2 | External event inputs, one per channel |
| gatePin | input | 2 | External gate inputs, one per channel |
| ackFlag | input | 2 | Clear-on-acknowledge for each overflow flag |
| ovfFlag | output | 2 | Overflow flags |

## Verification
Timer runs are started and stopped by run-bit writes committed exactly 12·N clock edges apart. Such a window holds exactly N machine-cycle ticks whatever the divider phase, so the counts are read back only after the stop edge. Event counts are sampled at least 30 clocks after the last falling edge, because a falling edge can wait up to 12 clocks for a sample and then another 12 for the increment. For the latency check, the bench first locates a tick edge by watching channel 1's timer and drops the pin just after that edge. It then expects channel 0 unchanged 23 clocks after that edge and incremented after 24. Staged, flag and byte writes are read back at the falling edge that follows the committing clock edge.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    MODE_PRESCALE = 2'd0,
    MODE_FULL     = 2'd1,
    MODE_RELOAD   = 2'd2,
    MODE_SPLIT    = 2'd3
  } tcMode_t;

  typedef struct packed {
    logic [1:0] inc;       // per-channel count enable for this clock
    logic       incSplit;  // channel 0 high byte as standalone counter
  } tcStrobe_t;

  localparam logic [2:0] ADDR_MODE = 3'd0;
  localparam logic [2:0] ADDR_CTRL = 3'd1;
  localparam logic [2:0] ADDR_LO0  = 3'd2;
  localparam logic [2:0] ADDR_HI0  = 3'd3;
  localparam logic [2:0] ADDR_LO1  = 3'd4;
  localparam logic [2:0] ADDR_HI1  = 3'd5;
endpackage

// File: rtl/tc_ctrl.sv
module tc_ctrl
  import tc_pkg::*;
#(
  parameter int CYCLE_DIV = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic       cycleEnd,
  input  logic [1:0] eventPin,
  input  logic [1:0] gatePin,
  output logic [7:0] modeAct,
  output logic [1:0] runAct,
  output tcStrobe_t  strobes
);
  localparam int DIV_W = (CYCLE_DIV > 1) ? $clog2(CYCLE_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CYCLE_DIV - 1);

  logic [7:0] modeStg, modeNext;
  logic [1:0] runStg, runNext;
  logic [DIV_W-1:0] divCnt;
  logic tick;
  logic [1:0] incRaw;
  logic splitOn, ch1Frozen;

  assign modeNext = (wrEn && wrAddr == ADDR_MODE) ? wrData : modeStg;
  assign runNext  = (wrEn && wrAddr == ADDR_CTRL) ? wrData[1:0] : runStg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeStg <= '0;
      runStg  <= '0;
      modeAct <= '0;
      runAct  <= '0;
    end else begin
      modeStg <= modeNext;
      runStg  <= runNext;
      if (cycleEnd) begin
        modeAct <= modeNext;
        runAct  <= runNext;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else if (tick) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end
  assign tick = (divCnt == DIV_LAST);

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic lastSample, fallSeen;
    logic gateOk, useEvents, evtOk;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lastSample <= 1'b0;
        fallSeen   <= 1'b0;
      end else if (tick) begin
        lastSample <= eventPin[ch];
        fallSeen   <= lastSample & ~eventPin[ch];
      end
    end

    assign gateOk     = ~modeAct[4*ch+3] | gatePin[ch];
    assign useEvents  = modeAct[4*ch+2];
    assign evtOk      = useEvents ? fallSeen : 1'b1;
    assign incRaw[ch] = tick & runAct[ch] & gateOk & evtOk;
  end

  assign splitOn   = (tcMode_t'(modeAct[1:0]) == MODE_SPLIT);
  assign ch1Frozen = splitOn | (tcMode_t'(modeAct[5:4]) == MODE_SPLIT);

  always_comb begin
    strobes.inc[0]   = incRaw[0];
    strobes.inc[1]   = incRaw[1] & ~ch1Frozen;
    strobes.incSplit = tick & runAct[1] & splitOn;
  end
endmodule

// File: rtl/tc_data.sv
module tc_data
  import tc_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [1:0]        ackFlag,
  input  logic [7:0]        modeAct,
  input  logic [1:0]        runAct,
  input  tcStrobe_t         strobes,
  input  logic [2:0]        rdAddr,
  output logic [BYTE_W-1:0] rdData,
  output logic [1:0]        ovfFlag
);
  localparam int FLAG_BIT = 4;

  logic [BYTE_W-1:0] cntLo [2];
  logic [BYTE_W-1:0] cntHi [2];
  logic [1:0] ovfMain, ovfSplit, setFlag;
  logic ctrlWr;

  assign ctrlWr = wrEn && (wrAddr == ADDR_CTRL);

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    localparam logic [2:0] LO_ADDR = 3'(2 + 2*ch);
    localparam logic [2:0] HI_ADDR = 3'(3 + 2*ch);
    tcMode_t chMode;
    logic [BYTE_W-1:0] lo, hi, loNext, hiNext;
    logic splitInc, ovfLo, ovfHi;

    assign chMode = tcMode_t'(modeAct[4*ch +: 2]);
    if (ch == 0) begin : g_split
      assign splitInc = strobes.incSplit;
    end else begin : g_nosplit
      assign splitInc = 1'b0;
    end

    always_comb begin
      loNext = lo;
      hiNext = hi;
      ovfLo  = 1'b0;
      ovfHi  = 1'b0;
      if (strobes.inc[ch]) begin
        unique case (chMode)
          MODE_PRESCALE: begin
            if (&lo[PRE_W-1:0]) begin
              loNext[PRE_W-1:0] = '0;
              {ovfLo, hiNext} = {1'b0, hi} + 1'b1;
            end else begin
              loNext[PRE_W-1:0] = lo[PRE_W-1:0] + 1'b1;
            end
          end
          MODE_FULL:
            {ovfLo, hiNext, loNext} = {1'b0, hi, lo} + 1'b1;
          MODE_RELOAD: begin
            if (&lo) begin
              loNext = hi;
              ovfLo  = 1'b1;
            end else begin
              loNext = lo + 1'b1;
            end
          end
          default:
            {ovfLo, loNext} = {1'b0, lo} + 1'b1;
        endcase
      end
      if (splitInc) {ovfHi, hiNext} = {1'b0, hi} + 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lo <= '0;
        hi <= '0;
      end else begin
        lo <= (wrEn && wrAddr == LO_ADDR) ? wrData : loNext;
        hi <= (wrEn && wrAddr == HI_ADDR) ? wrData : hiNext;
      end
    end

    assign cntLo[ch]    = lo;
    assign cntHi[ch]    = hi;
    assign ovfMain[ch]  = ovfLo;
    assign ovfSplit[ch] = ovfHi;
  end

  assign setFlag[0] = ovfMain[0];
  assign setFlag[1] = ovfMain[1] | ovfSplit[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag <= '0;
    end else begin
      for (int ch = 0; ch < 2; ch++) begin
        if (setFlag[ch]) ovfFlag[ch] <= 1'b1;
        else if (ackFlag[ch] || (ctrlWr && !wrData[FLAG_BIT+ch])) ovfFlag[ch] <= 1'b0;
      end
    end
  end

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      ADDR_MODE: rdData[7:0] = modeAct;
      ADDR_CTRL: rdData[7:0] = {2'b00, ovfFlag, 2'b00, runAct};
      ADDR_LO0:  rdData = cntLo[0];
      ADDR_HI0:  rdData = cntHi[0];
      ADDR_LO1:  rdData = cntLo[1];
      ADDR_HI1:  rdData = cntHi[1];
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/twin_timer.sv
module twin_timer
  import tc_pkg::*;
#(
  parameter int CYCLE_DIV = 12,
  parameter int PRE_W     = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [2:0] rdAddr,
  output logic [7:0] rdData,
  input  logic       cycleEnd,
  input  logic [1:0] eventPin,
  input  logic [1:0] gatePin,
  input  logic [1:0] ackFlag,
  output logic [1:0] ovfFlag
);
  logic [7:0] modeAct;
  logic [1:0] runAct;
  tcStrobe_t  strobes;

  tc_ctrl #(.CYCLE_DIV(CYCLE_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cycleEnd(cycleEnd), .eventPin(eventPin), .gatePin(gatePin),
    .modeAct(modeAct), .runAct(runAct), .strobes(strobes)
  );

  tc_data #(.BYTE_W(8), .PRE_W(PRE_W)) u_data (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ackFlag(ackFlag), .modeAct(modeAct), .runAct(runAct), .strobes(strobes),
    .rdAddr(rdAddr), .rdData(rdData), .ovfFlag(ovfFlag)
  );
endmodule

// File: rtl/twin_timer_check.sv
module twin_timer_check
  import tc_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       cycleEnd,
  input logic [7:0] modeAct,
  input logic [1:0] runAct,
  input tcStrobe_t  strobes,
  input logic [1:0] gatePin,
  input logic [1:0] ackFlag,
  input logic [1:0] ovfFlag
);
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cycleEnd |=> $stable(modeAct)); // R2
  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cycleEnd |=> $stable(runAct)); // R2
  AST_STOPPED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !runAct[0] |-> !strobes.inc[0]); // R3
  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    strobes.inc[0] |=> !strobes.inc[0]); // R3
  AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (modeAct[3] && !gatePin[0]) |-> !strobes.inc[0]); // R4
  AST_SPLIT_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (modeAct[1:0] == 2'd3) |-> !strobes.inc[1]); // R8
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag[0]) |-> $past(strobes.inc[0])); // R11
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (ackFlag[0] && !strobes.inc[0]) |=> !ovfFlag[0]); // R11
endmodule

bind twin_timer twin_timer_check u_check (
  .clk(clk), .rstN(rstN), .cycleEnd(cycleEnd), .modeAct(modeAct),
  .runAct(runAct), .strobes(strobes), .gatePin(gatePin),
  .ackFlag(ackFlag), .ovfFlag(ovfFlag)
);

// File: tb/twin_timer_test.sv
module twin_timer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic cycleEnd = 1'b0;
  logic [1:0] eventPin = 2'b11;
  logic [1:0] gatePin = 2'b00;
  logic [1:0] ackFlag = 2'b00;
  logic [1:0] ovfFlag;

  int testCount = 0;
  int failCount = 0;
  bit summaryDone = 1'b0;

  twin_timer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .cycleEnd(cycleEnd),
    .eventPin(eventPin), .gatePin(gatePin), .ackFlag(ackFlag), .ovfFlag(ovfFlag)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    end
    $finish;
  endtask

  // All tasks start and end just after a falling clock edge.
  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic ce);
    wrEn = 1'b1; wrAddr = a; wrData = d; cycleEnd = ce;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; cycleEnd = 1'b0;
  endtask

  task automatic commitOnly();
    cycleEnd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cycleEnd = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Run bits active for exactly 12*n clock edges; flags kept (bits 5:4 = 1).
  task automatic runTicks(input logic [1:0] runBits, input int n);
    wr(3'd1, {6'b110000, runBits} | 8'h30, 1'b1);
    idle(12 * n - 1);
    wr(3'd1, 8'h30, 1'b1);
  endtask

  function automatic logic [16:0] refRun(input int m, input logic [7:0] hiIn,
                                          input logic [7:0] loIn, input int n);
    logic [7:0] hi = hiIn;
    logic [7:0] lo = loIn;
    logic f = 1'b0;
    for (int i = 0; i < n; i++) begin
      case (m)
        0: begin
          if (lo[4:0] == 5'h1f) begin
            lo[4:0] = 5'h00;
            if (hi == 8'hff) f = 1'b1;
            hi = hi + 8'd1;
          end else lo[4:0] = lo[4:0] + 5'd1;
        end
        1: begin
          if ({hi, lo} == 16'hffff) f = 1'b1;
          {hi, lo} = {hi, lo} + 16'd1;
        end
        2: begin
          if (lo == 8'hff) begin lo = hi; f = 1'b1; end
          else lo = lo + 8'd1;
        end
        default: begin
          if (lo == 8'hff) f = 1'b1;
          lo = lo + 8'd1;
        end
      endcase
    end
    return {f, hi, lo};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
    finishRun();
  end

  initial begin
    logic [7:0] v, v2, v3;
    logic [16:0] ex;
    logic [7:0] preHi [4] = '{8'hff, 8'h00, 8'h7f, 8'hff};
    logic [7:0] preLo [4] = '{8'h1e, 8'h00, 8'hfd, 8'hfb};
    int nList [4] = '{1, 3, 7, 40};

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check(v == 8'h00, "R1 reset register", v, 0);
    end
    check(ovfFlag == 2'b00, "R1 reset flags", ovfFlag, 0);

    // R2 staging of mode and run bits
    wr(3'd0, 8'h11, 1'b0);
    rd(3'd0, v);
    check(v == 8'h00, "R2 mode staged", v, 8'h00);
    wr(3'd1, 8'h31, 1'b0);
    idle(36);
    rd(3'd2, v);
    check(v == 8'h00, "R2 run staged no count", v, 0);
    rd(3'd1, v);
    check(v == 8'h00, "R2 ctrl staged", v, 0);
    commitOnly();
    rd(3'd0, v);
    check(v == 8'h11, "R2 mode committed", v, 8'h11);
    rd(3'd1, v);
    check(v[1:0] == 2'b01, "R2 run committed", v, 8'h01);
    wr(3'd1, 8'h00, 1'b1);

    // R3 R5 R6 R7 sweep over modes, preloads and tick counts, both channels
    for (int ch = 0; ch < 2; ch++) begin
      for (int m = 0; m < 3; m++) begin
        wr(3'd0, 8'(m << (4 * ch)), 1'b1);
        for (int p = 0; p < 4; p++) begin
          for (int k = 0; k < 4; k++) begin
            wr(3'(2 + 2 * ch), preLo[p], 1'b0);
            wr(3'(3 + 2 * ch), preHi[p], 1'b0);
            wr(3'd1, 8'h00, 1'b1);
            runTicks(2'(1 << ch), nList[k]);
            ex = refRun(m, preHi[p], preLo[p], nList[k]);
            rd(3'(2 + 2 * ch), v);
            rd(3'(3 + 2 * ch), v2);
            check({ovfFlag[ch], v2, v} == ex,
                  (m == 0) ? "R5 prescaled count" : (m == 1) ? "R6 full count" : "R7 reload count",
                  {ovfFlag[ch], v2, v}, ex);
          end
        end
      end
    end

    // R3 stopped channel holds
    rd(3'd2, v);
    idle(50);
    rd(3'd2, v2);
    check(v == v2, "R3 stopped holds", v2, v);

    // R8 split mode
    wr(3'd0, 8'h13, 1'b1);
    wr(3'd2, 8'hf0, 1'b0);
    wr(3'd3, 8'hfa, 1'b0);
    wr(3'd4, 8'h55, 1'b0);
    wr(3'd5, 8'h66, 1'b0);
    wr(3'd1, 8'h00, 1'b1);
    runTicks(2'b11, 20);
    rd(3'd2, v);
    check(v == 8'h04, "R8 split low byte", v, 8'h04);
    rd(3'd3, v);
    check(v == 8'h0e, "R8 split high byte", v, 8'h0e);
    check(ovfFlag == 2'b11, "R8 split flags", ovfFlag, 3);
    rd(3'd4, v);
    rd(3'd5, v2);
    check({v2, v} == 16'h6655, "R8 channel 1 frozen", {v2, v}, 16'h6655);
    runTicks(2'b10, 3);
    rd(3'd2, v);
    rd(3'd3, v2);
    check({v2, v} == 16'h1104, "R8 high byte on run 1 only", {v2, v}, 16'h1104);

    // R11 flag clearing
    wr(3'd1, 8'h30, 1'b1);
    check(ovfFlag == 2'b11, "R11 write one keeps flags", ovfFlag, 3);
    ackFlag = 2'b01;
    @(negedge clk);
    ackFlag = 2'b00;
    check(ovfFlag == 2'b10, "R11 ack clears flag 0", ovfFlag, 2);
    wr(3'd1, 8'h10, 1'b0);
    rd(3'd1, v);
    check(v == 8'h00 && ovfFlag == 2'b00, "R11 write zero clears flag 1", v, 0);

    // R4 gate
    wr(3'd0, 8'h09, 1'b1);
    wr(3'd2, 8'h10, 1'b0);
    wr(3'd3, 8'h00, 1'b0);
    gatePin = 2'b00;
    runTicks(2'b01, 5);
    rd(3'd2, v);
    check(v == 8'h10, "R4 gate low blocks", v, 8'h10);
    gatePin = 2'b01;
    runTicks(2'b01, 5);
    rd(3'd2, v);
    check(v == 8'h15, "R4 gate high counts", v, 8'h15);
    gatePin = 2'b00;

    // R9 event counting; channel 1 runs as timer for phase finding
    wr(3'd0, 8'h15, 1'b0);
    wr(3'd2, 8'h00, 1'b0);
    wr(3'd3, 8'h00, 1'b0);
    eventPin = 2'b11;
    wr(3'd1, 8'h33, 1'b1);
    idle(30);
    rd(3'd2, v);
    check(v == 8'h00, "R9 steady pin no count", v, 0);
    for (int i = 0; i < 5; i++) begin
      eventPin[0] = 1'b0; idle(24);
      eventPin[0] = 1'b1; idle(24);
    end
    idle(30);
    rd(3'd2, v);
    check(v == 8'h05, "R9 five pulses", v, 5);

    // R10 latency: find a tick edge from channel 1 timer
    rd(3'd4, v3);
    v2 = v3;
    while (v2 == v3) begin
      @(negedge clk);
      rd(3'd4, v2);
    end
    eventPin[0] = 1'b0;
    idle(23);
    rd(3'd2, v);
    check(v == 8'h05, "R10 no increment before one machine cycle", v, 5);
    idle(1);
    rd(3'd2, v);
    check(v == 8'h06, "R10 increment after one machine cycle", v, 6);
    eventPin[0] = 1'b1;

    // R12 write while running
    wr(3'd4, 8'h80, 1'b0);
    rd(3'd4, v);
    check(v == 8'h80, "R12 written byte read back", v, 8'h80);
    idle(12);
    rd(3'd4, v);
    check(v == 8'h81, "R12 counts on from written value", v, 8'h81);
    wr(3'd1, 8'h30, 1'b1);

    finishRun();
  end
endmodule